// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block drives the strobes of an 8-bit microcontroller's external memory bus. It runs from the oscillator clock. A machine cycle is twelve oscillator periods, divided into six states of two periods each. In every machine cycle the block produces two address-latch pulses (active high), two program-read strobes (active low), and the byte that appears on the upper address port. The strobes run at fixed rates. In a machine cycle that carries an external data transfer, the block leaves out a defined set of pulses.

The control logic supplies one set of mode flags for each machine cycle. The block samples these flags on the clock edge that opens the cycle and holds them until the cycle ends. The flags are:
- external execution;
- a code-table read;
- an external data transfer;
- the address width of that data transfer.

A latch-disable bit, written through a one-bit configuration port, stops the address-latch pulses during ordinary internal execution. The reset pin is filtered. A reset counts only after the pin has stayed high for two full machine cycles.

Top module: `bss_top`

## Requirements
- R1: Phase p (0..11) of the machine cycle is counted from the cycle's first edge. With the latch-disable bit clear and no data transfer, `ale` is high for the outputs of phases 0,1 and 6,7 and low otherwise. This gives a 2-clock pulse every 6 clocks.
- R2: In a machine cycle flagged as a data transfer, the `ale` pulse of phases 0,1 is omitted and the pulse of phases 6,7 is kept.
- R3: The latch-disable bit is written from `cfg_din` when `cfg_wr` is high. A write on a cycle's first edge applies to that cycle. Reset clears the bit. While the bit is set, in internal execution, `ale` stays low unless the cycle is a data transfer or a code-table read.
- R4: While `ext_exec` is high, the latch-disable bit has no effect on `ale`.
- R5: When `ext_exec` or `code_rd` is high and the cycle is not a data transfer, `psen_n` is low for phases 2,3 and 8,9 and high otherwise. `ale` and `psen_n` are never active together.
- R6: In a data-transfer cycle, both `psen_n` activations are suppressed. With internal execution and no table read, `psen_n` stays high.
- R7: `p2_out` carries `addr_hi` in data-transfer cycles with `wide_addr` high, and in non-data cycles where `ext_exec` or `code_rd` is high.
- R8: `p2_out` carries `p2_latch` in data-transfer cycles with `wide_addr` low, and in cycles with internal execution and no table read.
- R9: Reset is taken only after `rst_in` is sampled high on 24 consecutive edges. A shorter pulse leaves the strobe timing undisturbed.
- R10: During reset, `ale`=0, `psen_n`=1 and `p2_out`=8'hFF. The first edge after `rst_in` falls still gives reset values. The next edge produces phase 0 of a new machine cycle.
- R11: The mode flags are sampled on a cycle's first edge. Changes to them later in the cycle have no effect until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset pin, active high, filtered |
| ext_exec | input | 1 | Code runs from external program memory |
| code_rd | input | 1 | Cycle performs a code-table read |
| data_acc | input | 1 | Cycle performs an external data transfer |
| wide_addr | input | 1 | Data transfer uses a 16-bit address |
| cfg_wr | input | 1 | Write strobe for the latch-disable bit |
| cfg_din | input | 1 | New value of the latch-disable bit |
| addr_hi | input | 8 | High byte of the current bus address |
| p2_latch | input | 8 | Contents of the upper-port output latch |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Program read strobe, active low |
| p2_out | output | 8 | Byte driven on the upper address port |

## Verification
Every output is registered. The value seen after the n-th edge following reset release is the decode of phase n mod 12, using the flags sampled at the edge where that cycle's phase was 0. The bench samples at the falling edge after each rising edge. It changes the mode flags, the configuration write and the reset pin only at falling edges, and it computes each expected value from n mod 12 and the flags it recorded for that cycle. The filter test holds `rst_in` high for 23 edges, then for 30 edges. After the second pulse the bench expects one extra reset-valued edge before phase 0.

// File: rtl/bss_pkg.sv
package bss_pkg;

    // Per-machine-cycle mode, sampled at the cycle's first edge
    typedef struct packed {
        logic ext_exec;
        logic code_rd;
        logic data_acc;
        logic wide_addr;
        logic ale_dis;
    } cyc_mode_t;

    // Registered strobe bundle
    typedef struct packed {
        logic       ale;
        logic       psen_n;
        logic [7:0] p2;
    } strobe_t;

    // Fixed state positions of the strobes inside a machine cycle
    localparam int ALE_FIRST  = 0;
    localparam int ALE_SECOND = 3;
    localparam int PSEN_FIRST = 1;
    localparam int PSEN_SECOND = 4;

    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1, p2: 8'hFF};

    function automatic strobe_t decode_strobe(input int state,
                                              input cyc_mode_t m,
                                              input logic [7:0] hi,
                                              input logic [7:0] latch);
        strobe_t r;
        logic ale_slot, psen_slot, ale_gate, fetch;
        ale_slot  = (state == ALE_FIRST) || (state == ALE_SECOND);
        psen_slot = (state == PSEN_FIRST) || (state == PSEN_SECOND);
        ale_gate  = !m.ale_dis || m.ext_exec || m.data_acc || m.code_rd;
        fetch     = m.ext_exec || m.code_rd;
        r.ale     = ale_slot && ale_gate && !(m.data_acc && state == ALE_FIRST);
        r.psen_n  = !(psen_slot && fetch && !m.data_acc);
        if (m.data_acc)
            r.p2 = m.wide_addr ? hi : latch;
        else
            r.p2 = fetch ? hi : latch;
        return r;
    endfunction

endpackage

// File: rtl/bss_timebase.sv
module bss_timebase #(
    parameter int CLK_PER_STATE = 2,
    parameter int STATES        = 6,
    parameter int RST_CYCLES    = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic sys_rst,
    output logic [$clog2(CLK_PER_STATE*STATES)-1:0] phase,
    output logic cyc_start
);
    localparam int CYC_LEN = CLK_PER_STATE * STATES;
    localparam int PH_W    = $clog2(CYC_LEN);
    localparam int RST_LIM = RST_CYCLES * CYC_LEN;
    localparam int CNT_W   = $clog2(RST_LIM + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(CYC_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_LIM);
    localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(RST_LIM - 1);

    logic [CNT_W-1:0] hi_cnt;

    // Consecutive-high counter for the reset pin
    always_ff @(posedge clk) begin
        if (!rst_in)
            hi_cnt <= '0;
        else if (hi_cnt != CNT_MAX)
            hi_cnt <= hi_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        sys_rst <= rst_in && (hi_cnt >= CNT_HIT);
    end

    always_ff @(posedge clk) begin
        if (sys_rst)
            phase <= '0;
        else if (phase == PH_LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign cyc_start = !sys_rst && (phase == '0);

    // R9
    filt_hold_chk: assert property (@(posedge clk)
        $rose(sys_rst) |-> ($past(rst_in) && $past(rst_in, 2)));

    // R10
    restart_phase_chk: assert property (@(posedge clk)
        $fell(sys_rst) |-> (phase == '0));

endmodule

// File: rtl/bss_cycle_ctrl.sv
module bss_cycle_ctrl
    import bss_pkg::*;
(
    input  logic      clk,
    input  logic      sys_rst,
    input  logic      cyc_start,
    input  logic      cfg_wr,
    input  logic      cfg_din,
    input  logic      ext_exec,
    input  logic      code_rd,
    input  logic      data_acc,
    input  logic      wide_addr,
    output cyc_mode_t mode
);
    logic      dis_q;
    logic      dis_next;
    cyc_mode_t live;
    cyc_mode_t held;

    assign dis_next = cfg_wr ? cfg_din : dis_q;

    always_comb begin
        live.ext_exec  = ext_exec;
        live.code_rd   = code_rd;
        live.data_acc  = data_acc;
        live.wide_addr = wide_addr;
        live.ale_dis   = dis_next;
    end

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            dis_q <= 1'b0;
            held  <= '0;
        end else begin
            dis_q <= dis_next;
            if (cyc_start)
                held <= live;
        end
    end

    // The cycle's first edge sees the live flags; the rest of the cycle sees the held copy
    assign mode = cyc_start ? live : held;

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (!cyc_start && !$past(cyc_start) && !$past(sys_rst)) |-> (mode.data_acc == $past(mode.data_acc)));

endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
    import bss_pkg::*;
#(
    parameter int CLK_PER_STATE = 2,
    parameter int STATES        = 6
) (
    input  logic       clk,
    input  logic       sys_rst,
    input  logic [$clog2(CLK_PER_STATE*STATES)-1:0] phase,
    input  cyc_mode_t  mode,
    input  logic [7:0] addr_hi,
    input  logic [7:0] p2_latch,
    output strobe_t    strobe
);
    int      state;
    strobe_t next_s;

    always_comb begin
        state  = int'(phase) / CLK_PER_STATE;
        next_s = decode_strobe(state, mode, addr_hi, p2_latch);
    end

    always_ff @(posedge clk) begin
        if (sys_rst)
            strobe <= STROBE_IDLE;
        else
            strobe <= next_s;
    end

    // R1
    ale_width_chk: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(strobe.ale) |=> strobe.ale);

    // R1
    ale_end_chk: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(strobe.ale) |-> ##2 !strobe.ale);

    // R5
    psen_width_chk: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(strobe.psen_n) |=> !strobe.psen_n);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (sys_rst)
        !(strobe.ale && !strobe.psen_n));

    // R2
    ale_skip_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (phase == '0 && mode.data_acc) |=> !strobe.ale);

    // R8
    narrow_p2_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (mode.data_acc && !mode.wide_addr) |=> (strobe.p2 == $past(p2_latch)));

endmodule

// File: rtl/bss_top.sv
module bss_top
    import bss_pkg::*;
#(
    parameter int CLK_PER_STATE = 2,
    parameter int STATES        = 6,
    parameter int RST_CYCLES    = 2
) (
    input  logic       clk,
    input  logic       rst_in,
    input  logic       ext_exec,
    input  logic       code_rd,
    input  logic       data_acc,
    input  logic       wide_addr,
    input  logic       cfg_wr,
    input  logic       cfg_din,
    input  logic [7:0] addr_hi,
    input  logic [7:0] p2_latch,
    output logic       ale,
    output logic       psen_n,
    output logic [7:0] p2_out
);
    localparam int PH_W = $clog2(CLK_PER_STATE * STATES);

    logic            sys_rst;
    logic            cyc_start;
    logic [PH_W-1:0] phase;
    cyc_mode_t       mode;
    strobe_t         strobe;

    bss_timebase #(
        .CLK_PER_STATE(CLK_PER_STATE),
        .STATES       (STATES),
        .RST_CYCLES   (RST_CYCLES)
    ) u_tb (
        .clk      (clk),
        .rst_in   (rst_in),
        .sys_rst  (sys_rst),
        .phase    (phase),
        .cyc_start(cyc_start)
    );

    bss_cycle_ctrl u_ctrl (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .cyc_start(cyc_start),
        .cfg_wr   (cfg_wr),
        .cfg_din  (cfg_din),
        .ext_exec (ext_exec),
        .code_rd  (code_rd),
        .data_acc (data_acc),
        .wide_addr(wide_addr),
        .mode     (mode)
    );

    bss_strobe_gen #(
        .CLK_PER_STATE(CLK_PER_STATE),
        .STATES       (STATES)
    ) u_gen (
        .clk     (clk),
        .sys_rst (sys_rst),
        .phase   (phase),
        .mode    (mode),
        .addr_hi (addr_hi),
        .p2_latch(p2_latch),
        .strobe  (strobe)
    );

    assign ale    = strobe.ale;
    assign psen_n = strobe.psen_n;
    assign p2_out = strobe.p2;

endmodule

// File: tb/tb_bss_top.sv
`timescale 1ns/1ps
module tb_bss_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_in = 1'b0, ext_exec = 1'b0, code_rd = 1'b0, data_acc = 1'b0, wide_addr = 1'b0;
    logic cfg_wr = 1'b0, cfg_din = 1'b0;
    logic [7:0] addr_hi = 8'h00, p2_latch = 8'h00;
    logic ale, psen_n;
    logic [7:0] p2_out;

    bss_top dut (
        .clk(clk), .rst_in(rst_in), .ext_exec(ext_exec), .code_rd(code_rd),
        .data_acc(data_acc), .wide_addr(wide_addr), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
        .addr_hi(addr_hi), .p2_latch(p2_latch), .ale(ale), .psen_n(psen_n), .p2_out(p2_out)
    );

    int errs = 0, checks = 0, n = 0;
    bit done = 0;
    // model of the flags governing the current machine cycle
    bit m_ext, m_code, m_data, m_wide, m_dis;

    task automatic chk(string tag, string what, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp_v);
        end
    endtask

    task automatic set_mode(bit e, bit c, bit d, bit w);
        m_ext = e; m_code = c; m_data = d; m_wide = w;
        ext_exec = e; code_rd = c; data_acc = d; wide_addr = w;
    endtask

    task automatic set_dis(bit v);
        cfg_wr = 1'b1; cfg_din = v; m_dis = v;
    endtask

    // Runs 'edges' rising edges, checking each result at the following falling edge
    task automatic run(int edges, bit scramble, int glitch, string force_tag);
        int g;
        g = glitch;
        if (g > 0) begin rst_in = 1'b1; g--; end
        for (int k = 0; k < edges; k++) begin
            logic [7:0] a_e, l_e, exp_p2;
            int ph, st;
            bit e_ale, e_psen_n, fetch;
            string t_ale, t_psen, t_p2;
            a_e = addr_hi; l_e = p2_latch;
            @(posedge clk);
            @(negedge clk);
            ph = n % 12; st = ph / 2;
            fetch = m_ext || m_code;
            e_ale = (st == 0 || st == 3) && (!m_dis || m_ext || m_data || m_code)
                    && !(m_data && st == 0);
            e_psen_n = !((st == 1 || st == 4) && fetch && !m_data);
            exp_p2 = m_data ? (m_wide ? a_e : l_e) : (fetch ? a_e : l_e);
            t_ale  = m_data ? "R2" : (m_dis ? (m_ext ? "R4" : "R3") : "R1");
            t_psen = m_data ? "R6" : (fetch ? "R5" : "R6");
            t_p2   = (m_data ? m_wide : fetch) ? "R7" : "R8";
            if (force_tag != "") begin t_ale = force_tag; t_psen = force_tag; t_p2 = force_tag; end
            chk(t_ale, "ale", int'(ale), int'(e_ale));
            chk(t_psen, "psen_n", int'(psen_n), int'(e_psen_n));
            chk(t_p2, "p2_out", int'(p2_out), int'(exp_p2));
            n++;
            cfg_wr = 1'b0;
            if (g > 0) begin rst_in = 1'b1; g--; end else rst_in = 1'b0;
            addr_hi  = addr_hi + 8'h35;
            p2_latch = p2_latch ^ 8'h5A ^ 8'(k);
            if (scramble && (n % 12) != 0) begin
                ext_exec = ~m_ext; code_rd = ~m_code; data_acc = ~m_data; wide_addr = ~m_wide;
            end else begin
                ext_exec = m_ext; code_rd = m_code; data_acc = m_data; wide_addr = m_wide;
            end
        end
    endtask

    task automatic do_reset();
        rst_in = 1'b1;
        repeat (30) @(negedge clk);
        // R10: reset state
        chk("R10", "ale_rst", int'(ale), 0);
        chk("R10", "psen_rst", int'(psen_n), 1);
        chk("R10", "p2_rst", int'(p2_out), 8'hFF);
        rst_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R10: first edge after release still gives reset values
        chk("R10", "ale_rel", int'(ale), 0);
        chk("R10", "psen_rel", int'(psen_n), 1);
        n = 0;
        m_dis = 0; // R3: reset clears the latch-disable bit
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        m_ext = 0; m_code = 0; m_data = 0; m_wide = 0; m_dis = 0;
        repeat (2) @(negedge clk);
        do_reset();
        addr_hi = 8'hA1; p2_latch = 8'h3C;
        set_mode(0, 0, 0, 0);
        run(24, 0, 0, "");                       // R1, R8, R6
        // sweep all flag combinations, one machine cycle each
        for (int v = 0; v < 32; v++) begin
            set_mode(v[0], v[1], v[2], v[3]);
            set_dis(v[4]);
            run(12, 0, 0, "");
        end
        // second pass with two cycles per combination, reversed order
        for (int v = 31; v >= 0; v--) begin
            set_mode(v[3], v[2], v[1], v[0]);
            set_dis(v[4]);
            run(24, 0, 0, "");
        end
        // R11: flags toggled inside the cycle are ignored
        set_dis(0);
        set_mode(1, 0, 1, 1); run(12, 1, 0, "R11");
        set_mode(0, 0, 0, 0); run(12, 1, 0, "R11");
        set_dis(1);
        set_mode(0, 1, 0, 0); run(12, 1, 0, "R11");
        // R9: 23-edge reset pulse leaves the timing undisturbed
        set_mode(1, 0, 0, 0);
        run(36, 0, 23, "R9");
        // R10 / R3: full reset at an unaligned phase with disable bit set
        set_dis(1);
        set_mode(0, 0, 0, 0);
        run(17, 0, 0, "");
        do_reset();
        set_mode(0, 0, 0, 0);
        run(24, 0, 0, "R10");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule